// File: doc/BRIEF.md
# Virtual Address Access Classifier

This block judges every 32-bit memory access a processor core makes. An access can be an instruction fetch, a data load or a data store, and it can come from user or supervisor mode. The block sorts each access into one of three outcomes:

- **Identity-mapped.** The page address passes through unchanged.
- **Translated.** The block uses the hit, the physical and virtual page bases, and the three permission bits that an external translation lookaside buffer presents with the request.
- **Faulting.** The block reports a fault cause. It also loads three values that the exception logic reads: the offending address, a flag marking a data-side access, and the virtual page number.

Fixed address windows apply:

- In supervisor mode, the top quarter of the address space skips translation.
- In user mode, the whole upper half is forbidden.

A probe request runs the same decision but only reports whether the access would succeed. It never raises a fault and never alters the stored fault values.

The result is registered. A request sampled on one rising edge produces a one-cycle done strobe and its outcome on the next cycle. The page size is a parameter; the default is 4 KiB, so the page number is address bits 31:12.

Top module: `vaccess_check`

## Requirements
- R1: After reset, every output is zero: done, success, fault, cause, physical page, bad address, data-side flag and page number.
- R2: Done rises in the cycle after each cycle with a valid request, and is low in the cycle after any cycle without one.
- R3: With the translation unit disabled by parameter, every access succeeds with the physical page equal to the address with its low page bits cleared, whatever the mode or lookup inputs.
- R4: A supervisor access at or above 0xC0000000 succeeds with the identity page address, even when the lookup reports a miss. A supervisor access at 0xBFFFF000 still goes through the lookup.
- R5: A user access at or above 0x80000000 faults regardless of the lookup. The cause is 1 for a fetch and 2 for a load or store. 0x7FFFF000 is still usable by user code.
- R6: On a hit with the needed permission, the physical page is the entry's physical base plus the page-aligned address minus the entry's virtual base.
- R7: A hit without the needed permission faults. Loads need read and fault with cause 3. Stores need write and fault with cause 4. Fetches need execute and fault with cause 5.
- R8: A miss faults with cause 6 for a fetch and cause 7 for a load or store.
- R9: On a non-probe fault, the bad address takes the full address, the data-side flag is 1 unless the access is a fetch, and the page number takes the address shifted right by the page bits. These values hold until the next non-probe fault.
- R10: A probe request that would fault reports done with success low, fault low and cause 0, and leaves the bad address, data-side flag and page number unchanged.
- R11: Success and fault are never high together. A successful access reports cause 0. A fault leaves the physical page output at its previous value.
- R12: The access-kind encoding is 0 for fetch, 1 for load and 2 for store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | 32 | Virtual address of the access |
| reqKind | input | 2 | 0 fetch, 1 load, 2 store |
| reqUser | input | 1 | 1 = user mode, 0 = supervisor |
| reqProbe | input | 1 | Query only, no fault side effects |
| lkHit | input | 1 | Lookup found a matching entry |
| lkPhysBase | input | 32 | Physical base of the matching entry |
| lkVirtBase | input | 32 | Virtual base of the matching entry |
| lkRead | input | 1 | Entry allows loads |
| lkWrite | input | 1 | Entry allows stores |
| lkExec | input | 1 | Entry allows fetches |
| doneValid | output | 1 | Result strobe, one cycle per request |
| okOut | output | 1 | Access succeeded |
| physAddr | output | 32 | Physical page address of last success |
| faultValid | output | 1 | Access raised a fault |
| faultCause | output | 3 | Cause code, 0 when none |
| badAddr | output | 32 | Address of the last raised fault |
| dataSide | output | 1 | Last raised fault was a load or store |
| faultVpn | output | 20 | Page number of the last raised fault |

## Verification
The assertions assume four things about the inputs:

- The lookup inputs are valid in the same cycle as the request they answer.
- The reset is held for at least one clock edge.
- The access kind never takes the unused code 3.
- The physical base and virtual base of an entry are page-aligned.

The stimulus drives every request from a single task. That task sets all lookup fields together with the address, uses only the three defined kinds, and always uses page-aligned entry bases. Each request lasts exactly one cycle, followed by an idle cycle, so every outcome is checked against the request that caused it.

// File: rtl/vac_pkg.sv
package vac_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } accKind_e;

  typedef enum logic [2:0] {
    CZ_NONE        = 3'd0,
    CZ_SUPER_FETCH = 3'd1,
    CZ_SUPER_DATA  = 3'd2,
    CZ_PERM_READ   = 3'd3,
    CZ_PERM_WRITE  = 3'd4,
    CZ_PERM_EXEC   = 3'd5,
    CZ_MISS_FETCH  = 3'd6,
    CZ_MISS_DATA   = 3'd7
  } cause_e;

  // strobes from the decision logic to the result registers
  typedef struct packed {
    logic   done;      // a request was sampled
    logic   pass;      // access succeeds
    logic   useXlate;  // take the translated page, not the identity page
    logic   raise;     // record a fault (never for probes)
    logic   dataAcc;   // load or store
    cause_e cause;     // cause to report, CZ_NONE unless raising
  } vacStrobe_t;

endpackage

// File: rtl/vac_ctrl.sv
module vac_ctrl
  import vac_pkg::*;
#(
  parameter int unsigned          ADDR_W     = 32,
  parameter bit                   MMU_EN     = 1'b1,
  parameter logic [ADDR_W-1:0]    SUPER_BASE = 32'hC000_0000,
  parameter logic [ADDR_W-1:0]    USER_LIMIT = 32'h8000_0000
) (
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqKind,
  input  logic              reqUser,
  input  logic              reqProbe,
  input  logic              lkHit,
  input  logic              lkRead,
  input  logic              lkWrite,
  input  logic              lkExec,
  output vacStrobe_t        stb
);

  accKind_e kind;
  logic     isFetch;
  logic     permOk;
  logic     bypassWin;
  logic     userForbid;
  logic     pass;
  logic     viaLookup;
  cause_e   why;

  assign kind    = accKind_e'(reqKind);
  assign isFetch = (kind == ACC_FETCH);

  // pick the permission bit the access kind needs; unused code 3 reads as a load
  always_comb begin
    unique case (kind)
      ACC_FETCH: permOk = lkExec;
      ACC_STORE: permOk = lkWrite;
      default:   permOk = lkRead;
    endcase
  end

  assign bypassWin  = !reqUser && (reqAddr >= SUPER_BASE);
  assign userForbid =  reqUser && (reqAddr >= USER_LIMIT);

  // ordered decision: window rules first, then lookup outcome
  always_comb begin
    pass      = 1'b0;
    viaLookup = 1'b0;
    why       = CZ_NONE;
    if (!MMU_EN) begin
      pass = 1'b1;
    end else if (bypassWin) begin
      pass = 1'b1;
    end else if (userForbid) begin
      why = isFetch ? CZ_SUPER_FETCH : CZ_SUPER_DATA;
    end else if (lkHit && permOk) begin
      pass      = 1'b1;
      viaLookup = 1'b1;
    end else if (lkHit) begin
      unique case (kind)
        ACC_FETCH: why = CZ_PERM_EXEC;
        ACC_STORE: why = CZ_PERM_WRITE;
        default:   why = CZ_PERM_READ;
      endcase
    end else begin
      why = isFetch ? CZ_MISS_FETCH : CZ_MISS_DATA;
    end
  end

  always_comb begin
    stb.done     = reqValid;
    stb.pass     = pass;
    stb.useXlate = viaLookup;
    stb.raise    = reqValid && !pass && !reqProbe;
    stb.dataAcc  = !isFetch;
    stb.cause    = (reqValid && !pass && !reqProbe) ? why : CZ_NONE;
  end

endmodule

// File: rtl/vac_dpath.sv
module vac_dpath
  import vac_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  vacStrobe_t        stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] lkPhysBase,
  input  logic [ADDR_W-1:0] lkVirtBase,
  output logic              doneQ,
  output logic              okQ,
  output logic              faultQ,
  output logic [2:0]        causeQ,
  output logic [ADDR_W-1:0] physQ,
  output logic [ADDR_W-1:0] badQ,
  output logic              dataQ,
  output logic [ADDR_W-PAGE_BITS-1:0] vpnQ
);

  localparam int unsigned VPN_W = ADDR_W - PAGE_BITS;
  localparam logic [ADDR_W-1:0] PAGE_MASK = {{VPN_W{1'b1}}, {PAGE_BITS{1'b0}}};

  logic [ADDR_W-1:0] pageAddr;
  logic [ADDR_W-1:0] xlatePage;
  logic [ADDR_W-1:0] nextPhys;

  assign pageAddr  = reqAddr & PAGE_MASK;
  assign xlatePage = (lkPhysBase + (pageAddr - lkVirtBase)) & PAGE_MASK;
  assign nextPhys  = stb.useXlate ? xlatePage : pageAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneQ  <= 1'b0;
      okQ    <= 1'b0;
      faultQ <= 1'b0;
      causeQ <= '0;
      physQ  <= '0;
      badQ   <= '0;
      dataQ  <= 1'b0;
      vpnQ   <= '0;
    end else begin
      doneQ  <= stb.done;
      okQ    <= stb.done && stb.pass;
      faultQ <= stb.raise;
      if (stb.done) causeQ <= stb.cause;
      if (stb.done && stb.pass) physQ <= nextPhys;
      if (stb.raise) begin
        badQ  <= reqAddr;
        dataQ <= stb.dataAcc;
        vpnQ  <= reqAddr[ADDR_W-1:PAGE_BITS];
      end
    end
  end

  // R2: the strobe follows the request by exactly one cycle
  p_done_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.done |=> doneQ);
  p_no_stray_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.done |=> !doneQ);
  // R11: outcomes are exclusive, and a fault always carries a cause
  p_ok_xor_fault_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(okQ && faultQ));
  p_cause_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    faultQ |-> (causeQ != 3'd0));
  // R9: stored fault values change only when a fault is raised
  p_hold_bad_r9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.raise |=> $stable(badQ) && $stable(vpnQ) && $stable(dataQ));

endmodule

// File: rtl/vaccess_check.sv
module vaccess_check
  import vac_pkg::*;
#(
  parameter bit MMU_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [31:0] reqAddr,
  input  logic [1:0]  reqKind,
  input  logic        reqUser,
  input  logic        reqProbe,
  input  logic        lkHit,
  input  logic [31:0] lkPhysBase,
  input  logic [31:0] lkVirtBase,
  input  logic        lkRead,
  input  logic        lkWrite,
  input  logic        lkExec,
  output logic        doneValid,
  output logic        okOut,
  output logic [31:0] physAddr,
  output logic        faultValid,
  output logic [2:0]  faultCause,
  output logic [31:0] badAddr,
  output logic        dataSide,
  output logic [19:0] faultVpn
);

  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned PAGE_BITS = 12;

  vacStrobe_t stb;

  vac_ctrl #(
    .ADDR_W(ADDR_W), .MMU_EN(MMU_EN),
    .SUPER_BASE(32'hC000_0000), .USER_LIMIT(32'h8000_0000)
  ) u_ctrl (
    .reqValid(reqValid), .reqAddr(reqAddr), .reqKind(reqKind),
    .reqUser(reqUser), .reqProbe(reqProbe), .lkHit(lkHit),
    .lkRead(lkRead), .lkWrite(lkWrite), .lkExec(lkExec), .stb(stb)
  );

  vac_dpath #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr),
    .lkPhysBase(lkPhysBase), .lkVirtBase(lkVirtBase),
    .doneQ(doneValid), .okQ(okOut), .faultQ(faultValid), .causeQ(faultCause),
    .physQ(physAddr), .badQ(badAddr), .dataQ(dataSide), .vpnQ(faultVpn)
  );

  // R10: a probe never raises a fault
  p_probe_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqProbe) |=> !faultValid);

  generate
    if (MMU_EN) begin : g_win
      // R4: supervisor top window is identity mapped
      p_bypass_r4: assert property (@(posedge clk) disable iff (!rstN)
        (reqValid && !reqUser && reqAddr[31:30] == 2'b11)
          |=> okOut && physAddr == {$past(reqAddr[31:12]), 12'h000});
      // R5: user upper half never succeeds
      p_user_forbid_r5: assert property (@(posedge clk) disable iff (!rstN)
        (reqValid && reqUser && reqAddr[31]) |=> !okOut);
    end else begin : g_flat
      // R3: without translation every access succeeds
      p_flat_ok_r3: assert property (@(posedge clk) disable iff (!rstN)
        reqValid |=> okOut && !faultValid);
    end
  endgenerate

endmodule

// File: tb/sim_vaccess_check.sv
module sim_vaccess_check;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqKind = '0;
  logic        reqUser = 1'b0;
  logic        reqProbe = 1'b0;
  logic        lkHit = 1'b0;
  logic [31:0] lkPhysBase = '0;
  logic [31:0] lkVirtBase = '0;
  logic        lkRead = 1'b0, lkWrite = 1'b0, lkExec = 1'b0;

  logic        doneValid, okOut, faultValid, dataSide;
  logic [31:0] physAddr, badAddr;
  logic [2:0]  faultCause;
  logic [19:0] faultVpn;

  logic        fDone, fOk, fFault, fData;
  logic [31:0] fPhys, fBad;
  logic [2:0]  fCause;
  logic [19:0] fVpn;

  int errs = 0;
  int checks = 0;

  always #4 clk = ~clk;  // 125 MHz

  vaccess_check #(.MMU_EN(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqKind(reqKind), .reqUser(reqUser), .reqProbe(reqProbe), .lkHit(lkHit),
    .lkPhysBase(lkPhysBase), .lkVirtBase(lkVirtBase), .lkRead(lkRead),
    .lkWrite(lkWrite), .lkExec(lkExec), .doneValid(doneValid), .okOut(okOut),
    .physAddr(physAddr), .faultValid(faultValid), .faultCause(faultCause),
    .badAddr(badAddr), .dataSide(dataSide), .faultVpn(faultVpn)
  );

  vaccess_check #(.MMU_EN(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqKind(reqKind), .reqUser(reqUser), .reqProbe(reqProbe), .lkHit(lkHit),
    .lkPhysBase(lkPhysBase), .lkVirtBase(lkVirtBase), .lkRead(lkRead),
    .lkWrite(lkWrite), .lkExec(lkExec), .doneValid(fDone), .okOut(fOk),
    .physAddr(fPhys), .faultValid(fFault), .faultCause(fCause),
    .badAddr(fBad), .dataSide(fData), .faultVpn(fVpn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one request for one cycle; return at the following negedge with results visible
  task automatic issue(input logic [31:0] a, input logic [1:0] k, input logic u,
                       input logic p, input logic h, input logic [31:0] pb,
                       input logic [31:0] vb, input logic r, input logic w,
                       input logic x);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqKind = k; reqUser = u; reqProbe = p;
    lkHit = h; lkPhysBase = pb; lkVirtBase = vb;
    lkRead = r; lkWrite = w; lkExec = x;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expect_fault(input string req, input logic [31:0] a,
                              input logic [2:0] c, input logic d);
    chk({req, " done"}, doneValid, 1);
    chk({req, " ok"}, okOut, 0);
    chk({req, " fault"}, faultValid, 1);
    chk({req, " cause"}, faultCause, c);
    chk("R9 bad", badAddr, a);
    chk("R9 dataSide", dataSide, d);
    chk("R9 vpn", faultVpn, a[31:12]);
  endtask

  task automatic t_reset;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 done", doneValid, 0);  chk("R1 ok", okOut, 0);
    chk("R1 fault", faultValid, 0); chk("R1 cause", faultCause, 0);
    chk("R1 phys", physAddr, 0);    chk("R1 bad", badAddr, 0);
    chk("R1 data", dataSide, 0);    chk("R1 vpn", faultVpn, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R2 idle no done", doneValid, 0);
  endtask

  task automatic t_strobe;
    // R12 kind 1 = load, hit with read, translated
    issue(32'h1234_5678, 2'd1, 1'b1, 1'b0, 1'b1, 32'h0ABC_D000, 32'h1234_5000, 1, 0, 0);
    chk("R2 done", doneValid, 1);
    chk("R6 ok", okOut, 1);
    chk("R11 cause", faultCause, 0);
    chk("R6 phys", physAddr, 32'h0ABC_D000);
    @(negedge clk);
    chk("R2 single pulse", doneValid, 0);
  endtask

  task automatic t_translate;
    // R6 multi-page entry, fetch needs execute
    issue(32'h0040_3ABC, 2'd0, 1'b0, 1'b0, 1'b1, 32'h2000_0000, 32'h0040_0000, 0, 0, 1);
    chk("R6 ok", okOut, 1);
    chk("R6 phys", physAddr, 32'h2000_3000);
    // R5 boundary: user just below the forbidden half
    issue(32'h7FFF_F004, 2'd2, 1'b1, 1'b0, 1'b1, 32'h0010_0000, 32'h7FFF_F000, 0, 1, 0);
    chk("R5 user low ok", okOut, 1);
    chk("R5 user low phys", physAddr, 32'h0010_0000);
  endtask

  task automatic t_bypass;
    issue(32'hC000_1234, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 0, 0, 0);
    chk("R4 ok", okOut, 1);
    chk("R4 phys", physAddr, 32'hC000_1000);
    // below the window a supervisor miss on a store faults
    issue(32'hBFFF_F008, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 1, 1, 1);
    expect_fault("R4 edge R8", 32'hBFFF_F008, 3'd7, 1'b1);
    chk("R11 phys held", physAddr, 32'hC000_1000);
  endtask

  task automatic t_user_forbid;
    issue(32'h9000_0010, 2'd0, 1'b1, 1'b0, 1'b1, 32'h0, 32'h9000_0000, 1, 1, 1);
    expect_fault("R5 fetch", 32'h9000_0010, 3'd1, 1'b0);
    issue(32'hC000_0000, 2'd1, 1'b1, 1'b0, 1'b1, 32'h0, 32'hC000_0000, 1, 1, 1);
    expect_fault("R5 data", 32'hC000_0000, 3'd2, 1'b1);
  endtask

  task automatic t_perm;
    issue(32'h0001_2345, 2'd1, 1'b1, 1'b0, 1'b1, 32'h5000_0000, 32'h0001_2000, 0, 1, 1);
    expect_fault("R7 read", 32'h0001_2345, 3'd3, 1'b1);
    issue(32'h0002_3456, 2'd2, 1'b0, 1'b0, 1'b1, 32'h5000_0000, 32'h0002_3000, 1, 0, 1);
    expect_fault("R7 write", 32'h0002_3456, 3'd4, 1'b1);
    issue(32'h0003_4567, 2'd0, 1'b1, 1'b0, 1'b1, 32'h5000_0000, 32'h0003_4000, 1, 1, 0);
    expect_fault("R7 exec", 32'h0003_4567, 3'd5, 1'b0);
  endtask

  task automatic t_miss;
    issue(32'h0FED_C123, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0, 1, 1, 1);
    expect_fault("R8 fetch", 32'h0FED_C123, 3'd6, 1'b0);
    issue(32'h0ABC_0FFC, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 1, 1, 1);
    expect_fault("R8 load", 32'h0ABC_0FFC, 3'd7, 1'b1);
  endtask

  task automatic t_probe;
    // stored values now hold the last miss (0x0ABC0FFC, data side)
    issue(32'h0555_5000, 2'd0, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0, 0, 0, 0);
    chk("R10 done", doneValid, 1);
    chk("R10 ok", okOut, 0);
    chk("R10 fault", faultValid, 0);
    chk("R10 cause", faultCause, 0);
    chk("R10 bad", badAddr, 32'h0ABC_0FFC);
    chk("R10 data", dataSide, 1);
    chk("R10 vpn", faultVpn, 20'h0ABC0);
    // a passing probe still reports success
    issue(32'h0030_0010, 2'd1, 1'b0, 1'b1, 1'b1, 32'h7700_0000, 32'h0030_0000, 1, 0, 0);
    chk("R10 pass ok", okOut, 1);
    chk("R10 pass phys", physAddr, 32'h7700_0000);
  endtask

  task automatic t_nommu;
    issue(32'hFFFF_F123, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0, 0, 0, 0);
    chk("R3 done", fDone, 1);
    chk("R3 ok", fOk, 1);
    chk("R3 fault", fFault, 0);
    chk("R3 phys", fPhys, 32'hFFFF_F000);
    chk("R3 bad untouched", fBad, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_strobe();
        t_translate();
        t_bypass();
        t_user_forbid();
        t_perm();
        t_miss();
        t_probe();
        t_nommu();
      end
      begin
        repeat (5000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule